// File: doc/BRIEF.md
# Return-from-exception load sequencer

This block takes the return-from-exception instruction from an execution pipeline, decodes it and checks whether it may run. A legal instruction then makes two word reads from memory: the first word becomes the new program counter and the second becomes the status word to be restored. The instruction arrives as its upper halfword together with a flag that tells the fixed-width form from the compressed form. The lower halfword has a fixed value in every form and is not an input.

The pipeline supplies the base-register value with the instruction. It also supplies the current privilege level and whether the instruction sits inside a conditional block, and if so whether it is the last instruction there. An encoding that is not recognised, or one that the privilege level forbids, gives a one-cycle flag pulse and no memory traffic. A legal instruction holds `busy` high while its two reads run over a valid/ready request channel and a response channel. After both reads succeed, the block pulses the return outputs and, when write-back was requested, a register write port in the same cycle.

Top module: `rfe_seq`

## Requirements
- R1: When `ins_narrow`=0 the upper halfword is the fixed-width form when bits[15:9]=1111100, bit6=0 and bit4=1. In that form bit8 is P, bit7 is U (1 = increment), bit5 is W and bits[3:0] are the base register index.
- R2: When `ins_narrow`=1 the upper halfword must have bit4=1 and bits[15:6] equal to either 1110100000 (always decrement) or 1110100110 (always increment). Bit5 is W and bits[3:0] are the index. Any halfword that matches neither form under the given flag is undefined.
- R3: The start address is the base when incrementing and base−8 when decrementing, plus 4 in the fixed-width form when P equals U. The first read uses the start address and the second uses start+4, and they are issued in that order.
- R4: The data of the first read appears on `ret_pc` and the data of the second on `ret_status`. `ret_valid` is high for exactly one cycle, the cycle after the second response is accepted.
- R5: When W=1, `wb_en` pulses together with `ret_valid`, with `wb_idx` set to the base index and `wb_val` set to base+8 (increment) or base−8 (decrement). When W=0, `wb_en` stays low.
- R6: A request stays valid with an unchanged address until `mem_req_ready` is high at a clock edge.
- R7: A response that has `mem_rsp_err` set ends the sequence at once. No further read is issued, neither `ret_valid` nor `wb_en` is raised, and `busy` falls in the next cycle.
- R8: `busy` is high from the cycle after acceptance until the cycle after the `ret_valid` pulse. An `ins_valid` that arrives while `busy` is high is ignored.
- R9: A base index of 15, or a compressed form with `cb_inside`=1 and `cb_last`=0, pulses `flag_unpred` in the cycle after acceptance and issues no request. An instruction in the fixed-width form does not depend on the conditional-block inputs.
- R10: Privilege level 2 (`priv_lvl`=2'd2) pulses `flag_undef` in the cycle after acceptance and issues no request. Levels 1 and 3 execute.
- R11: At privilege level 0 the instruction is undefined (a `flag_undef` pulse) when the parameter `L0_UNDEF`=1. When `L0_UNDEF`=0 it is a no-op, with no flag, no request and no return.
- R12: The checks apply in this priority order: an unrecognised encoding is undefined; then the unpredictable cases of R9; then the privilege rules of R10 and R11. `flag_undef` and `flag_unpred` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction offered this cycle |
| ins_upper | input | 16 | Upper halfword of the instruction |
| ins_narrow | input | 1 | 1 = compressed form, 0 = fixed-width form |
| cb_inside | input | 1 | Instruction lies inside a conditional block |
| cb_last | input | 1 | Instruction is the last one of its conditional block |
| priv_lvl | input | 2 | Current privilege level |
| base_val | input | DW | Value of the base register |
| busy | output | 1 | Sequence in progress; new instructions are ignored |
| flag_undef | output | 1 | One-cycle pulse: instruction undefined |
| flag_unpred | output | 1 | One-cycle pulse: instruction unpredictable |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | DW | Read byte address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DW | Read data |
| mem_rsp_err | input | 1 | Read failed |
| ret_valid | output | 1 | One-cycle exception-return pulse |
| ret_pc | output | DW | New program counter |
| ret_status | output | DW | Status word to restore |
| wb_en | output | 1 | Base-register write enable |
| wb_idx | output | 4 | Base-register index |
| wb_val | output | DW | Adjusted base value |

## Verification
Some properties are checked by assertions on every cycle. A stalled request holds its address. Each return is a single pulse followed by `busy` falling. A write-back never occurs without a return. An error response never leads to a return or write-back. A flagged instruction never starts a read, and the two flags are never raised together.

Other behaviour can only be shown by the bench's scenarios with known expected values. These cover the start address for each addressing mode and form, wrap-around below address zero, the pairing of read data with the PC and status outputs, and the write-back value. They also cover the legality priority order, the effect of the level-0 parameter, and an instruction offered while busy being dropped.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

    localparam int RN_W    = 4;
    localparam int HALF_W  = 16;
    localparam int WORD_B  = 4;
    localparam int PAIR_B  = 2 * WORD_B;
    localparam logic [RN_W-1:0] RN_BAD = '1;

    typedef enum logic [1:0] {
        OUT_EXEC,
        OUT_UNDEF,
        OUT_UNPRED,
        OUT_NOP
    } outcome_e;

    typedef struct packed {
        logic            known;
        logic            narrow;
        logic            incr;
        logic            high;
        logic            wback;
        logic [RN_W-1:0] rn;
    } dec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LO,
        ST_RSP_LO,
        ST_REQ_HI,
        ST_RSP_HI,
        ST_DONE
    } st_e;

    function automatic logic [1:0] priv_code(input int lvl);
        return 2'(lvl);
    endfunction

endpackage

// File: rtl/rfe_decode.sv
module rfe_decode
    import rfe_pkg::*;
(
    input  logic [HALF_W-1:0] up,
    input  logic              narrow,
    output dec_t              dec
);
    logic fixed_hit, dec_hit, inc_hit;

    always_comb begin
        fixed_hit = !narrow && (up[15:9] == 7'b1111100) && !up[6] && up[4];
        dec_hit   = narrow && (up[15:6] == 10'b1110100000) && up[4];
        inc_hit   = narrow && (up[15:6] == 10'b1110100110) && up[4];

        dec.known  = fixed_hit || dec_hit || inc_hit;
        dec.narrow = narrow;
        dec.incr   = fixed_hit ? up[7] : inc_hit;
        dec.high   = fixed_hit && (up[8] == up[7]);
        dec.wback  = up[5];
        dec.rn     = up[RN_W-1:0];
    end
endmodule

// File: rtl/rfe_legal.sv
module rfe_legal
    import rfe_pkg::*;
#(
    parameter bit L0_UNDEF = 1'b0
) (
    input  dec_t       dec,
    input  logic [1:0] priv,
    input  logic       cb_in,
    input  logic       cb_last,
    output outcome_e   res
);
    always_comb begin
        if (!dec.known)
            res = OUT_UNDEF;
        else if (dec.rn == RN_BAD || (dec.narrow && cb_in && !cb_last))
            res = OUT_UNPRED;
        else if (priv == priv_code(2))
            res = OUT_UNDEF;
        else if (priv == priv_code(0))
            res = L0_UNDEF ? OUT_UNDEF : OUT_NOP;
        else
            res = OUT_EXEC;
    end
endmodule

// File: rtl/rfe_addr.sv
module rfe_addr
    import rfe_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] base,
    input  logic          incr,
    input  logic          high,
    output logic [DW-1:0] start,
    output logic [DW-1:0] adj
);
    localparam logic [DW-1:0] PAIR = DW'(PAIR_B);
    localparam logic [DW-1:0] WORD = DW'(WORD_B);

    logic [DW-1:0] low;

    always_comb begin
        low   = incr ? base : base - PAIR;
        start = high ? low + WORD : low;
        adj   = incr ? base + PAIR : base - PAIR;
    end
endmodule

// File: rtl/rfe_seq.sv
module rfe_seq
    import rfe_pkg::*;
#(
    parameter int DW       = 32,
    parameter bit L0_UNDEF = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [HALF_W-1:0] ins_upper,
    input  logic              ins_narrow,
    input  logic              cb_inside,
    input  logic              cb_last,
    input  logic [1:0]        priv_lvl,
    input  logic [DW-1:0]     base_val,
    output logic              busy,
    output logic              flag_undef,
    output logic              flag_unpred,
    output logic              mem_req_valid,
    output logic [DW-1:0]     mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              ret_valid,
    output logic [DW-1:0]     ret_pc,
    output logic [DW-1:0]     ret_status,
    output logic              wb_en,
    output logic [RN_W-1:0]   wb_idx,
    output logic [DW-1:0]     wb_val
);
    localparam logic [DW-1:0] WORD = DW'(WORD_B);

    dec_t          dec;
    outcome_e      verdict;
    logic [DW-1:0] start_a, adj_v;

    st_e           st;
    logic [DW-1:0] addr_r;
    logic          wb_req;

    rfe_decode u_dec (
        .up     (ins_upper),
        .narrow (ins_narrow),
        .dec    (dec)
    );

    rfe_legal #(.L0_UNDEF(L0_UNDEF)) u_legal (
        .dec     (dec),
        .priv    (priv_lvl),
        .cb_in   (cb_inside),
        .cb_last (cb_last),
        .res     (verdict)
    );

    rfe_addr #(.DW(DW)) u_addr (
        .base  (base_val),
        .incr  (dec.incr),
        .high  (dec.high),
        .start (start_a),
        .adj   (adj_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            addr_r      <= '0;
            wb_req      <= 1'b0;
            wb_idx      <= '0;
            wb_val      <= '0;
            ret_pc      <= '0;
            ret_status  <= '0;
            flag_undef  <= 1'b0;
            flag_unpred <= 1'b0;
        end else begin
            flag_undef  <= 1'b0;
            flag_unpred <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (ins_valid) begin
                        unique case (verdict)
                            OUT_EXEC: begin
                                st     <= ST_REQ_LO;
                                addr_r <= start_a;
                                wb_req <= dec.wback;
                                wb_idx <= dec.rn;
                                wb_val <= adj_v;
                            end
                            OUT_UNDEF:  flag_undef  <= 1'b1;
                            OUT_UNPRED: flag_unpred <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_REQ_LO: if (mem_req_ready) st <= ST_RSP_LO;
                ST_RSP_LO: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            st <= ST_IDLE;
                        end else begin
                            ret_pc <= mem_rsp_data;
                            addr_r <= addr_r + WORD;
                            st     <= ST_REQ_HI;
                        end
                    end
                end
                ST_REQ_HI: if (mem_req_ready) st <= ST_RSP_HI;
                ST_RSP_HI: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            st <= ST_IDLE;
                        end else begin
                            ret_status <= mem_rsp_data;
                            st         <= ST_DONE;
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (st != ST_IDLE);
    assign mem_req_valid = (st == ST_REQ_LO) || (st == ST_REQ_HI);
    assign mem_req_addr  = addr_r;
    assign ret_valid     = (st == ST_DONE);
    assign wb_en         = (st == ST_DONE) && wb_req;

    // R6: a stalled request keeps its address
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R4 and R8: the return is a single pulse, after which busy falls
    p_ret_single_r4: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> !ret_valid && !busy);

    // R5: write-back only together with the return
    p_wb_with_ret_r5: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ret_valid);

    // R7: an error response while waiting aborts the sequence
    p_err_abort_r7: assert property (@(posedge clk) disable iff (rst)
        busy && !mem_req_valid && !ret_valid && mem_rsp_valid && mem_rsp_err
        |=> !ret_valid && !wb_en && !busy);

    // R9 and R10: a flagged instruction starts no read
    p_flag_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        flag_undef || flag_unpred |-> !busy && !mem_req_valid);

    // R12: the two flags are exclusive
    p_flag_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(flag_undef && flag_unpred));

endmodule

// File: tb/rfe_seq_test.sv
module rfe_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [15:0] ins_upper = '0;
    logic        ins_narrow = 1'b0;
    logic        cb_inside = 1'b0;
    logic        cb_last = 1'b0;
    logic [1:0]  priv_lvl = 2'd1;
    logic [31:0] base_val = '0;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    logic        busy, flag_undef, flag_unpred, mem_req_valid, ret_valid, wb_en;
    logic [31:0] mem_req_addr, ret_pc, ret_status, wb_val;
    logic [3:0]  wb_idx;

    logic        b_busy, b_undef, b_unpred, b_req_valid, b_ret_valid, b_wb_en;
    logic [31:0] b_req_addr, b_ret_pc, b_ret_status, b_wb_val;
    logic [3:0]  b_wb_idx;

    always #5 clk = ~clk;

    rfe_seq #(.DW(32), .L0_UNDEF(1'b0)) uut (
        .clk, .rst, .ins_valid, .ins_upper, .ins_narrow, .cb_inside, .cb_last,
        .priv_lvl, .base_val, .busy, .flag_undef, .flag_unpred, .mem_req_valid,
        .mem_req_addr, .mem_req_ready, .mem_rsp_valid, .mem_rsp_data, .mem_rsp_err,
        .ret_valid, .ret_pc, .ret_status, .wb_en, .wb_idx, .wb_val
    );

    rfe_seq #(.DW(32), .L0_UNDEF(1'b1)) uut_l0 (
        .clk, .rst, .ins_valid, .ins_upper, .ins_narrow, .cb_inside, .cb_last,
        .priv_lvl, .base_val, .busy(b_busy), .flag_undef(b_undef), .flag_unpred(b_unpred),
        .mem_req_valid(b_req_valid), .mem_req_addr(b_req_addr), .mem_req_ready,
        .mem_rsp_valid, .mem_rsp_data, .mem_rsp_err, .ret_valid(b_ret_valid),
        .ret_pc(b_ret_pc), .ret_status(b_ret_status), .wb_en(b_wb_en),
        .wb_idx(b_wb_idx), .wb_val(b_wb_val)
    );

    int errs = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] memw(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    // memory model and output monitor
    int stall_len = 0, stall_ctr = 0, err_idx = -1, nreq = 0;
    int nret = 0, nwb = 0, nun = 0, nunp = 0, nun_b = 0;
    logic [31:0] alog [4];
    logic [31:0] got_pc, got_st, got_wbv;
    logic [3:0]  got_idx;
    bit          pend = 0;
    logic [31:0] paddr;
    int          pidx;

    initial begin
        forever begin
            @(negedge clk);
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memw(paddr);
                mem_rsp_err   = (pidx == err_idx);
                pend = 0;
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end
            if (mem_req_valid) begin
                if (stall_ctr < stall_len) begin
                    mem_req_ready = 1'b0;
                    stall_ctr++;
                end else begin
                    mem_req_ready = 1'b1;
                    stall_ctr = 0;
                    pend  = 1;
                    paddr = mem_req_addr;
                    pidx  = nreq;
                    if (nreq < 4) alog[nreq] = mem_req_addr;
                    nreq++;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
            if (ret_valid) begin nret++; got_pc = ret_pc; got_st = ret_status; end
            if (wb_en) begin nwb++; got_wbv = wb_val; got_idx = wb_idx; end
            if (flag_undef) nun++;
            if (flag_unpred) nunp++;
            if (b_undef) nun_b++;
        end
    end

    task automatic clear();
        nreq = 0; nret = 0; nwb = 0; nun = 0; nunp = 0; nun_b = 0;
        stall_ctr = 0;
    endtask

    task automatic offer(input logic [15:0] up, input bit nar, input logic [1:0] pv,
                         input bit ci, input bit cl, input logic [31:0] base);
        ins_upper = up; ins_narrow = nar; priv_lvl = pv;
        cb_inside = ci; cb_last = cl; base_val = base;
        ins_valid = 1'b1;
    endtask

    task automatic settle();
        for (int k = 0; k < 60; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk);
        #1;
    endtask

    task automatic run(input logic [15:0] up, input bit nar, input logic [1:0] pv,
                       input bit ci, input bit cl, input logic [31:0] base);
        clear();
        @(negedge clk);
        offer(up, nar, pv, ci, cl, base);
        @(negedge clk);
        ins_valid = 1'b0;
        settle();
    endtask

    localparam logic [1:0] K_EX = 2'd0, K_UD = 2'd1, K_UP = 2'd2, K_NP = 2'd3;

    typedef struct packed {
        logic [15:0] up;
        logic        nar;
        logic [1:0]  pv;
        logic        ci;
        logic        cl;
        logic [31:0] base;
        logic [1:0]  kind;
        logic [31:0] a0;
        logic        wb;
        logic [31:0] wbv;
        logic [3:0]  idx;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VT [NV] = '{
        '{16'hF833, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_1000, K_EX, 32'h0000_0FFC, 1'b1, 32'h0000_0FF8, 4'd3},
        '{16'hF914, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_2000, K_EX, 32'h0000_1FF8, 1'b0, 32'h0,         4'd4},
        '{16'hF8B5, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_3000, K_EX, 32'h0000_3000, 1'b1, 32'h0000_3008, 4'd5},
        '{16'hF9B0, 1'b0, 2'd3, 1'b0, 1'b0, 32'h0000_4000, K_EX, 32'h0000_4004, 1'b1, 32'h0000_4008, 4'd0},
        '{16'hE836, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0000_5000, K_EX, 32'h0000_4FF8, 1'b1, 32'h0000_4FF8, 4'd6},
        '{16'hE997, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0000_6000, K_EX, 32'h0000_6000, 1'b0, 32'h0,         4'd7},
        '{16'hE9B8, 1'b1, 2'd1, 1'b1, 1'b1, 32'h0000_7000, K_EX, 32'h0000_7000, 1'b1, 32'h0000_7008, 4'd8},
        '{16'hF83F, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_1000, K_UP, 32'h0,         1'b0, 32'h0,         4'd0},
        '{16'hE832, 1'b1, 2'd1, 1'b1, 1'b0, 32'h0000_1000, K_UP, 32'h0,         1'b0, 32'h0,         4'd0},
        '{16'hF8B5, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0000_3000, K_UD, 32'h0,         1'b0, 32'h0,         4'd0},
        '{16'hF8B5, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_3000, K_NP, 32'h0,         1'b0, 32'h0,         4'd0},
        '{16'hF8F5, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_3000, K_UD, 32'h0,         1'b0, 32'h0,         4'd0},
        '{16'hF833, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0000_1000, K_UD, 32'h0,         1'b0, 32'h0,         4'd0},
        '{16'hF83F, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0000_1000, K_UP, 32'h0,         1'b0, 32'h0,         4'd0},
        '{16'hE832, 1'b1, 2'd2, 1'b1, 1'b0, 32'h0000_1000, K_UP, 32'h0,         1'b0, 32'h0,         4'd0},
        '{16'hF914, 1'b0, 2'd1, 1'b1, 1'b0, 32'h0000_2000, K_EX, 32'h0000_1FF8, 1'b0, 32'h0,         4'd4},
        '{16'hF914, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_0004, K_EX, 32'hFFFF_FFFC, 1'b0, 32'h0,         4'd4}
    };

    task automatic expect_exec(input logic [31:0] a0, input bit wb, input logic [31:0] wbv,
                               input logic [3:0] idx, input string tag);
        chk(nreq == 2, {tag, " R3 request count"}, 32'(nreq), 32'd2);
        chk(alog[0] == a0, {tag, " R1/R2/R3 first address"}, alog[0], a0);
        chk(alog[1] == a0 + 32'd4, {tag, " R3 second address"}, alog[1], a0 + 32'd4);
        chk(nret == 1, {tag, " R4 return pulses"}, 32'(nret), 32'd1);
        chk(got_pc == memw(a0), {tag, " R4 pc"}, got_pc, memw(a0));
        chk(got_st == memw(a0 + 32'd4), {tag, " R4 status"}, got_st, memw(a0 + 32'd4));
        chk(nwb == int'(wb), {tag, " R5 writeback count"}, 32'(nwb), 32'(wb));
        if (wb) begin
            chk(got_wbv == wbv, {tag, " R5 writeback value"}, got_wbv, wbv);
            chk(got_idx == idx, {tag, " R5 writeback index"}, 32'(got_idx), 32'(idx));
        end
        chk(nun == 0 && nunp == 0, {tag, " R12 no flags"}, 32'(nun + nunp), 32'd0);
    endtask

    bit finished = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !mem_req_valid, "reset R8 busy/request", {30'd0, busy, mem_req_valid}, 32'd0);
        chk(!ret_valid && !wb_en, "reset R4/R5 return/writeback", {30'd0, ret_valid, wb_en}, 32'd0);
        chk(!flag_undef && !flag_unpred, "reset R12 flags", {30'd0, flag_undef, flag_unpred}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run(VT[i].up, VT[i].nar, VT[i].pv, VT[i].ci, VT[i].cl, VT[i].base);
            case (VT[i].kind)
                K_EX: expect_exec(VT[i].a0, VT[i].wb, VT[i].wbv, VT[i].idx, $sformatf("vec%0d", i));
                K_UD: begin
                    chk(nun == 1 && nunp == 0, $sformatf("vec%0d R10/R12 undef flag", i), 32'(nun), 32'd1);
                    chk(nreq == 0 && nret == 0, $sformatf("vec%0d R10 no access", i), 32'(nreq), 32'd0);
                end
                K_UP: begin
                    chk(nunp == 1 && nun == 0, $sformatf("vec%0d R9/R12 unpred flag", i), 32'(nunp), 32'd1);
                    chk(nreq == 0 && nret == 0, $sformatf("vec%0d R9 no access", i), 32'(nreq), 32'd0);
                end
                default: begin
                    chk(nun == 0 && nunp == 0 && nreq == 0 && nret == 0,
                        $sformatf("vec%0d R11 no-op", i), 32'(nun + nunp + nreq + nret), 32'd0);
                    chk(nun_b == 1, $sformatf("vec%0d R11 level0 undef variant", i), 32'(nun_b), 32'd1);
                end
            endcase
        end

        // R6: back-pressure on both requests
        stall_len = 3;
        run(16'hF833, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_1000);
        expect_exec(32'h0000_0FFC, 1'b1, 32'h0000_0FF8, 4'd3, "stall R6");
        stall_len = 0;

        // R7: error on the first read
        err_idx = 0;
        run(16'hF8B5, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_3000);
        chk(nreq == 1, "R7 first-read error stops second request", 32'(nreq), 32'd1);
        chk(nret == 0 && nwb == 0, "R7 first-read error no return", 32'(nret + nwb), 32'd0);
        chk(!busy, "R7 busy cleared", 32'(busy), 32'd0);

        // R7: error on the second read
        err_idx = 1;
        run(16'hF8B5, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_3000);
        chk(nreq == 2, "R7 second-read error request count", 32'(nreq), 32'd2);
        chk(nret == 0 && nwb == 0, "R7 second-read error no return", 32'(nret + nwb), 32'd0);
        err_idx = -1;

        // R8: an instruction offered while busy is ignored
        clear();
        @(negedge clk);
        offer(16'hF8B5, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_3000);
        @(negedge clk);
        chk(busy, "R8 busy after accept", 32'(busy), 32'd1);
        offer(16'hF9B0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_4000);
        @(negedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        settle();
        chk(nreq == 2 && alog[1] == 32'h0000_3004, "R8 only first instruction ran", alog[1], 32'h0000_3004);
        chk(nret == 1 && got_wbv == 32'h0000_3008, "R8 single return", got_wbv, 32'h0000_3008);
        repeat (4) @(negedge clk);
        #1;
        chk(nreq == 2 && !busy, "R8 no later sequence", 32'(nreq), 32'd2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule